// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects a vector of interrupt sources and turns them into two request lines and one wake line. Each source has a three-bit sense code that selects one of five behaviours:

- rising edge
- falling edge
- either edge
- active-high level
- active-low level

A source can also be switched off. Edge events are held in two separate latches, one for rising and one for falling, and software clears them by writing ones. Level events follow the synchronised input directly.

Software configures the block through a single write port and a combinational read port. Every control vector has three addresses: one to read it, one to set bits and one to clear bits. A single source can therefore be reprogrammed without a read-modify-write. Two status vectors report the pending, unmasked sources on each request line. A per-source wake enable feeds the wake line, and the mask has no effect on it.

A per-source source-select bit chooses the input. It is either the external pin or a bit of a software-written test register, so interrupt paths can be exercised without outside stimulus.

Top module: `ic_top`

## Requirements
- R1: After reset, all control vectors, latches and the test register read 0, except the route vector, which reads all ones. `reqOut` and `wakeOut` are 0.
- R2: Address = group*4 + op, where op 0 reads the group, op 1 ORs wrData into it and op 2 clears the bits where wrData is 1. Groups: 0 sense bit0, 1 sense bit1, 2 sense bit2, 3 mask, 4 wake, 5 route, 6 source select. Bits written as 0 keep their value.
- R3: The sense code {bit2,bit1,bit0} is 001 rising, 010 falling, 011 both edges, 101 high level and 110 low level. Codes 000, 100 and 111 never make a source pending.
- R4: Rising and falling events are latched separately and read at address 23 (rising) and 27 (falling). Writing 1 to address 7 clears rising latch bits, and writing 1 to address 11 clears falling latch bits. A new event in the same cycle wins over the clear.
- R5: In level modes, pending follows the synchronised input and no edge latch is set.
- R6: A source with route bit 1 goes to `reqOut[0]`, and one with route bit 0 goes to `reqOut[1]`. Address 15 reads the status for request 0 and address 19 reads the status for request 1. Each status is pending AND mask AND the route match.
- R7: A pending source drives a request line only while its mask bit is 1.
- R8: `wakeOut` is the OR over sources that are pending and have their wake bit at 1, whatever the mask.
- R9: A source-select bit of 1 takes the external input, and 0 takes the matching bit of the test register. The test register is written and read at address 3.
- R10: Each input passes two synchroniser flops. A level shows on the outputs two clock edges after it is sampled, and an edge latch sets one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | NUM_SRC | Raw interrupt inputs |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write address |
| wrData | input | NUM_SRC | Write data, one bit per source |
| rdAddr | input | 5 | Read address |
| rdData | output | NUM_SRC | Read data, combinational |
| reqOut | output | 2 | Request lines 0 and 1 |
| wakeOut | output | 1 | Wake line |

## Verification
The assertions assume that `wrData` is a full one-bit-per-source vector in every cycle `wrEn` is high. They also assume that set and clear actions reach the mask only through the single write port, so no second agent changes it between cycles. The stimulus drives every write and input change half a period away from the active edge and holds each input level for six cycles. That is longer than the synchroniser and latch path, so no pulse is shorter than the detection window. Latches are cleared before each new edge pattern, so stale events from a previous mode never reach a check.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int ADDR_W   = 5;
  localparam int NUM_GRP  = 7;
  localparam int GRP_CFG0 = 0;
  localparam int GRP_CFG1 = 1;
  localparam int GRP_CFG2 = 2;
  localparam int GRP_MASK = 3;
  localparam int GRP_WAKE = 4;
  localparam int GRP_ASGN = 5;
  localparam int GRP_SRC  = 6;
  localparam int OP_RD    = 0;
  localparam int OP_SET   = 1;
  localparam int OP_CLR   = 2;
  localparam int OP_AUX   = 3;

  typedef struct packed {
    logic [NUM_GRP-1:0] setStb;
    logic [NUM_GRP-1:0] clrStb;
    logic               riseClr;
    logic               fallClr;
    logic               testWr;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_TEST, RD_STAT0, RD_STAT1, RD_RISE, RD_FALL
  } rdsel_t;
endpackage

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           stb,
  output rdsel_t            rdSel,
  output logic [2:0]        rdGrp
);
  logic [2:0] wGrp;
  logic [1:0] wOp;
  logic [1:0] rOp;

  assign wGrp  = wrAddr[ADDR_W-1:2];
  assign wOp   = wrAddr[1:0];
  assign rdGrp = rdAddr[ADDR_W-1:2];
  assign rOp   = rdAddr[1:0];

  always_comb begin
    stb = '0;
    if (wrEn && (int'(wGrp) < NUM_GRP)) begin
      unique case (int'(wOp))
        OP_SET: stb.setStb[wGrp] = 1'b1;
        OP_CLR: stb.clrStb[wGrp] = 1'b1;
        OP_AUX: begin
          if (int'(wGrp) == 0) stb.testWr  = 1'b1;
          if (int'(wGrp) == 1) stb.riseClr = 1'b1;
          if (int'(wGrp) == 2) stb.fallClr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (int'(rdGrp) < NUM_GRP) begin
      if (int'(rOp) == OP_RD) rdSel = RD_CTL;
      else if (int'(rOp) == OP_AUX) begin
        unique case (int'(rdGrp))
          0:       rdSel = RD_TEST;
          3:       rdSel = RD_STAT0;
          4:       rdSel = RD_STAT1;
          5:       rdSel = RD_RISE;
          6:       rdSel = RD_FALL;
          default: rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  strobe_t            stb,
  input  rdsel_t             rdSel,
  input  logic [2:0]         rdGrp,
  output logic [NUM_SRC-1:0] rdData,
  output logic [1:0]         reqOut,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] pendVec
);
  logic [NUM_GRP-1:0][NUM_SRC-1:0] ctlReg;
  logic [NUM_SRC-1:0] testReg, rawIn, syncA, syncB, prevB;
  logic [NUM_SRC-1:0] riseLat, fallLat, riseEv, fallEv;
  logic [NUM_SRC-1:0] riseEn, fallEn, hiLvl, loLvl;
  logic [NUM_SRC-1:0] stat0, stat1;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ctl
    localparam logic [NUM_SRC-1:0] RST_VAL = (g == GRP_ASGN) ? '1 : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctlReg[g] <= RST_VAL;
      else if (stb.setStb[g]) ctlReg[g] <= ctlReg[g] | wrData;
      else if (stb.clrStb[g]) ctlReg[g] <= ctlReg[g] & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) testReg <= '0;
    else if (stb.testWr) testReg <= wrData;
  end

  assign rawIn = (ctlReg[GRP_SRC] & irqIn) | (~ctlReg[GRP_SRC] & testReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseEv = syncB & ~prevB;
  assign fallEv = ~syncB & prevB;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mode
    logic [2:0] mode;
    assign mode      = {ctlReg[GRP_CFG2][i], ctlReg[GRP_CFG1][i], ctlReg[GRP_CFG0][i]};
    assign riseEn[i] = (mode == 3'b001) || (mode == 3'b011);
    assign fallEn[i] = (mode == 3'b010) || (mode == 3'b011);
    assign hiLvl[i]  = (mode == 3'b101);
    assign loLvl[i]  = (mode == 3'b110);
    assign pendVec[i] = (hiLvl[i] & syncB[i]) | (loLvl[i] & ~syncB[i]) |
                        (riseEn[i] & riseLat[i]) | (fallEn[i] & fallLat[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseLat <= '0;
      fallLat <= '0;
    end else begin
      riseLat <= (riseLat & ~(stb.riseClr ? wrData : '0)) | (riseEv & riseEn);
      fallLat <= (fallLat & ~(stb.fallClr ? wrData : '0)) | (fallEv & fallEn);
    end
  end

  assign maskVec = ctlReg[GRP_MASK];
  assign stat0   = pendVec & maskVec & ctlReg[GRP_ASGN];
  assign stat1   = pendVec & maskVec & ~ctlReg[GRP_ASGN];
  assign reqOut  = {|stat1, |stat0};
  assign wakeOut = |(pendVec & ctlReg[GRP_WAKE]);

  always_comb begin
    unique case (rdSel)
      RD_CTL:   rdData = (int'(rdGrp) < NUM_GRP) ? ctlReg[rdGrp] : '0;
      RD_TEST:  rdData = testReg;
      RD_STAT0: rdData = stat0;
      RD_STAT1: rdData = stat1;
      RD_RISE:  rdData = riseLat;
      RD_FALL:  rdData = fallLat;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/ic_top.sv
module ic_top
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic [1:0]         reqOut,
  output logic               wakeOut
);
  strobe_t            stb;
  rdsel_t             rdSel;
  logic [2:0]         rdGrp;
  logic [NUM_SRC-1:0] maskVec, pendVec;

  ic_ctrl i_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .stb(stb), .rdSel(rdSel), .rdGrp(rdGrp)
  );

  ic_datapath #(.NUM_SRC(NUM_SRC)) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrData(wrData),
    .stb(stb), .rdSel(rdSel), .rdGrp(rdGrp), .rdData(rdData),
    .reqOut(reqOut), .wakeOut(wakeOut), .maskVec(maskVec), .pendVec(pendVec)
  );
endmodule

// File: rtl/ic_checker.sv
module ic_checker
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NUM_SRC-1:0] wrData,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [1:0]         reqOut,
  input logic               wakeOut
);
  localparam logic [ADDR_W-1:0] MASK_SET = ADDR_W'(GRP_MASK * 4 + OP_SET);
  localparam logic [ADDR_W-1:0] MASK_CLR = ADDR_W'(GRP_MASK * 4 + OP_CLR);

  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == MASK_SET) |=> ((maskVec & $past(wrData)) == $past(wrData)));

  a_r2_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == MASK_CLR) |=> ((maskVec & $past(wrData)) == '0));

  a_r2_mask_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == MASK_SET) |=> (((maskVec ^ $past(maskVec)) & ~$past(wrData)) == '0));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> (reqOut == 2'b00));

  a_r8_wake_pending: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (pendVec != '0));
endmodule

bind ic_top ic_checker #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .maskVec(maskVec), .pendVec(pendVec), .reqOut(reqOut), .wakeOut(wakeOut)
);

// File: tb/test_ic_top.sv
`timescale 1ns/100ps
module test_ic_top;
  localparam int N = 32;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [N-1:0] irqIn = '0, wrData = '0, rdData;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [1:0] reqOut;
  logic wakeOut;
  int tests = 0, fails = 0;

  ic_top #(.NUM_SRC(N)) i_ic_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .reqOut(reqOut),
    .wakeOut(wakeOut)
  );

  always #2.5 clk = ~clk;

  // row: {mode[2:0], startLevel, endLevel, expectedPending}
  localparam logic [5:0] VEC [13] = '{
    6'b001_0_1_1, 6'b001_1_0_0, 6'b010_1_0_1, 6'b010_0_1_0,
    6'b011_0_1_1, 6'b011_1_0_1, 6'b101_0_1_1, 6'b101_1_0_0,
    6'b110_1_0_1, 6'b110_0_1_0, 6'b000_0_1_0, 6'b100_0_1_0,
    6'b111_0_1_0
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input int src, input logic [2:0] mode);
    for (int b = 0; b < 3; b++) begin
      wr(5'(b * 4 + 2), N'(1) << src);
      if (mode[b]) wr(5'(b * 4 + 1), N'(1) << src);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    waitCyc(3);
    // R1 reset values
    rd(5'd20, v); chk("R1 route reset", v, '1);
    rd(5'd0, v);  chk("R1 sense0 reset", v, '0);
    rd(5'd12, v); chk("R1 mask reset", v, '0);
    rd(5'd3, v);  chk("R1 test reset", v, '0);
    chk("R1 outputs reset", {30'd0, reqOut}, {31'd0, wakeOut});
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 outputs after reset", {29'd0, wakeOut, reqOut}, '0);

    // table: R3 sense codes, R5 level follow, R10 latency window
    wr(5'd25, N'(1) << 5);
    wr(5'd13, N'(1) << 5);
    for (int k = 0; k < 13; k++) begin
      setMode(5, VEC[k][5:3]);
      irqIn[5] = VEC[k][2];
      waitCyc(6);
      wr(5'd7, N'(1) << 5);
      wr(5'd11, N'(1) << 5);
      irqIn[5] = VEC[k][1];
      waitCyc(6);
      rd(5'd15, v);
      chk($sformatf("R3 row %0d status0", k), v, VEC[k][0] ? (N'(1) << 5) : '0);
      chk($sformatf("R3 row %0d reqOut0", k), N'(reqOut[0]), N'(VEC[k][0]));
    end

    // R2 set/clear with zero bits kept
    wr(5'd14, '1);
    wr(5'd13, 32'h0000_00F0);
    wr(5'd13, 32'h0000_0003);
    rd(5'd12, v); chk("R2 set keeps others", v, 32'h0000_00F3);
    wr(5'd14, 32'h0000_0030);
    rd(5'd12, v); chk("R2 clear keeps others", v, 32'h0000_00C3);
    wr(5'd14, '1);

    // R6 routing to request 1
    irqIn = '0;
    setMode(5, 3'b101);
    irqIn[5] = 1'b1;
    wr(5'd13, N'(1) << 5);
    wr(5'd22, N'(1) << 5);
    waitCyc(6);
    chk("R6 route to req1", N'(reqOut), N'(2'b10));
    rd(5'd19, v); chk("R6 status1", v, N'(1) << 5);
    rd(5'd15, v); chk("R6 status0 empty", v, '0);

    // R7 mask gating
    wr(5'd14, N'(1) << 5);
    waitCyc(1);
    chk("R7 masked request", N'(reqOut), '0);
    rd(5'd19, v); chk("R7 masked status1", v, '0);

    // R8 wake ignores mask
    wr(5'd17, N'(1) << 5);
    waitCyc(1);
    chk("R8 wake while masked", N'(wakeOut), N'(1));
    irqIn[5] = 1'b0;
    waitCyc(6);
    chk("R8 wake drops with input", N'(wakeOut), '0);
    wr(5'd18, N'(1) << 5);

    // R5 level mode does not latch
    irqIn[5] = 1'b1; waitCyc(6); irqIn[5] = 1'b0; waitCyc(6);
    rd(5'd23, v); chk("R5 no rise latch in level", v, '0);
    rd(5'd27, v); chk("R5 no fall latch in level", v, '0);

    // R4 separate latches and clears
    setMode(7, 3'b011);
    wr(5'd25, N'(1) << 7);
    irqIn[7] = 1'b1; waitCyc(6); irqIn[7] = 1'b0; waitCyc(6);
    rd(5'd23, v); chk("R4 rise latched", v, N'(1) << 7);
    rd(5'd27, v); chk("R4 fall latched", v, N'(1) << 7);
    wr(5'd7, N'(1) << 7);
    rd(5'd23, v); chk("R4 rise cleared", v, '0);
    rd(5'd27, v); chk("R4 fall kept", v, N'(1) << 7);
    wr(5'd11, N'(1) << 7);
    rd(5'd27, v); chk("R4 fall cleared", v, '0);

    // R9 source select from test register
    setMode(7, 3'b000);
    setMode(9, 3'b101);
    wr(5'd26, N'(1) << 9);
    wr(5'd13, N'(1) << 9);
    irqIn[9] = 1'b1;
    waitCyc(6);
    chk("R9 pin ignored when test selected", N'(reqOut), '0);
    wr(5'd3, N'(1) << 9);
    waitCyc(6);
    chk("R9 test bit drives req0", N'(reqOut), N'(2'b01));
    rd(5'd3, v); chk("R9 test readback", v, N'(1) << 9);
    wr(5'd3, '0);
    waitCyc(6);
    chk("R9 test bit cleared", N'(reqOut), '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule